// File: doc/BRIEF.md
# Dual Parallel Port with Direction Control

This block holds the register state for two 8-bit parallel ports, called A and B, behind a small register bus. The bus has a 4-bit offset, a write strobe with byte-wide write data, and a byte-wide read value that follows the offset combinationally. Each port has an output register and a direction register. A direction bit of 1 makes its pin an output, so the block enables its pin driver and presents the output register bit there. A direction bit of 0 leaves the pin as an input.

Port A can be written at two offsets. The normal one also tells a separate interrupt block to clear the two port A control-line flags. The quiet one updates the port and sends nothing. A write to port B data requests that the two port B control-line flags be cleared. Each of these requests is a one-cycle pulse on a 4-bit vector. Reading a data offset returns the output register bit for each output pin and a 1 for each input pin.

Top module: `gpio_dual_port`

## Requirements
- R1: The port B direction register sits at offset 0x2 and the port A direction register at offset 0x3. A write stores the byte as given, and a read at that offset returns it unchanged.
- R2: A write to port B data at offset 0x0 stores the write data ANDed with the port B direction register into the port B output register. A write to port A data at offset 0x1 or 0xF does the same for port A. Bits whose direction is 0 are stored as 0.
- R3: A read at offset 0x0 (port B), 0x1 or 0xF (port A) returns the output register bit where the direction bit is 1 and returns 1 where the direction bit is 0.
- R4: The pin value outputs equal the output registers, and the pin output enables equal the direction registers, bit for bit.
- R5: A write at offset 0x1 makes `flag_clr` equal 4'b1100 for the one clock cycle that follows the write edge. Bit 3 is CA2, bit 2 is CA1, bit 1 is CB2 and bit 0 is CB1.
- R6: A write at offset 0x0 makes `flag_clr` equal 4'b0011 for the one clock cycle that follows the write edge.
- R7: A write at offset 0xF, at either direction offset, or at any unmapped offset leaves `flag_clr` at zero in the following cycle.
- R8: A read at an unmapped offset (0x4 to 0xE) returns 0x00. A write there changes no register and no pin.
- R9: While reset is active, and right after it, both output registers and both direction registers are zero. Every pin is then an input, data reads return 0xFF, and `flag_clr` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 4 | Register offset for the write and for the read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read value at `bus_addr`, combinational |
| pa_out | output | 8 | Port A pin values |
| pa_oe | output | 8 | Port A pin output enables |
| pb_out | output | 8 | Port B pin values |
| pb_oe | output | 8 | Port B pin output enables |
| flag_clr | output | 4 | One-cycle flag clear requests {CA2, CA1, CB2, CB1} |

## Verification
A register write takes effect at the rising edge that samples the strobe. From then on the pins and the combinational read value show the new state, with no further delay. The flag-clear vector comes from one register stage, so it is high only in the cycle between the write edge and the next edge. The bench drives a write at a falling edge and sets the read offset at the next falling edge. It samples 1 ns after that, which places every read, pin and `flag_clr` check in the one cycle where each result is due. A pair of back-to-back writes shows that the pulse drops after one cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Register offsets: fixed, software depends on them
  typedef enum logic [3:0] {
    OFS_PB_DATA  = 4'h0,
    OFS_PA_DATA  = 4'h1,
    OFS_PB_DIR   = 4'h2,
    OFS_PA_DIR   = 4'h3,
    OFS_PA_QUIET = 4'hF
  } reg_ofs_e;

  // Port index used for the per-port arrays
  localparam int PORT_B = 0;
  localparam int PORT_A = 1;
  localparam int NUM_PORTS = 2;

  // Bit positions in the flag-clear vector
  localparam int FLG_CB1 = 0;
  localparam int FLG_CB2 = 1;
  localparam int FLG_CA1 = 2;
  localparam int FLG_CA2 = 3;
  localparam int FLG_W   = 4;

endpackage

// File: rtl/gpio_decode.sv
module gpio_decode
  import gpio_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        addr,
  output logic [NUM_PORTS-1:0] wr_dat,
  output logic [NUM_PORTS-1:0] wr_dir,
  output logic                 hs_a,
  output logic                 hs_b
);

  logic hit_pb, hit_pa, hit_pq, hit_db, hit_da;

  always_comb begin
    hit_pb = (addr == AW'(OFS_PB_DATA));
    hit_pa = (addr == AW'(OFS_PA_DATA));
    hit_pq = (addr == AW'(OFS_PA_QUIET));
    hit_db = (addr == AW'(OFS_PB_DIR));
    hit_da = (addr == AW'(OFS_PA_DIR));
  end

  always_comb begin
    wr_dat[PORT_B] = wr_en && hit_pb;
    wr_dat[PORT_A] = wr_en && (hit_pa || hit_pq);
    wr_dir[PORT_B] = wr_en && hit_db;
    wr_dir[PORT_A] = wr_en && hit_da;
    hs_a           = wr_en && hit_pa;
    hs_b           = wr_en && hit_pb;
  end

  // R8
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_dat, wr_dir}))
    else $error("more than one register selected");

  // R7
  quiet_no_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat[PORT_A] && !hs_a |-> !hs_b)
    else $error("quiet port A write raised a handshake clear");

endmodule

// File: rtl/gpio_port_reg.sv
module gpio_port_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_dat,
  input  logic          wr_dir,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] out_q,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] view
);

  // Only pins configured as outputs keep written bits
  function automatic logic [DW-1:0] masked_store(input logic [DW-1:0] d,
                                                 input logic [DW-1:0] dir);
    return d & dir;
  endfunction

  // Input pins read as 1, output pins show the stored value
  function automatic logic [DW-1:0] read_view(input logic [DW-1:0] o,
                                              input logic [DW-1:0] dir);
    return (o & dir) | ~dir;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      if (wr_dat) out_q <= masked_store(wdata, dir_q);
      if (wr_dir) dir_q <= wdata;
    end
  end

  always_comb view = read_view(out_q, dir_q);

  // R1
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(wdata))
    else $error("direction register did not take the written byte");

  // R1
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_q))
    else $error("direction register changed without a write");

  // R2
  out_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat |=> (out_q & ~$past(dir_q)) == '0)
    else $error("output register stored a bit of an input pin");

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dat |=> $stable(out_q))
    else $error("output register changed without a write");

endmodule

// File: rtl/gpio_flag_pulse.sv
module gpio_flag_pulse
  import gpio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_a,
  input  logic             clr_b,
  output logic [FLG_W-1:0] flag_clr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_clr <= '0;
    end else begin
      flag_clr[FLG_CA2] <= clr_a;
      flag_clr[FLG_CA1] <= clr_a;
      flag_clr[FLG_CB2] <= clr_b;
      flag_clr[FLG_CB1] <= clr_b;
    end
  end

  // R5
  a_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_a |=> flag_clr[FLG_CA1] && flag_clr[FLG_CA2])
    else $error("port A write gave no CA clear pulse");

  // R6
  b_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_b |=> flag_clr[FLG_CB1] && flag_clr[FLG_CB2])
    else $error("port B write gave no CB clear pulse");

  // R7
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_a && !clr_b |=> flag_clr == '0)
    else $error("flag clear without a handshake write");

endmodule

// File: rtl/gpio_dual_port.sv
module gpio_dual_port
  import gpio_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  output logic [3:0]    flag_clr
);

  logic [NUM_PORTS-1:0] wr_dat, wr_dir;
  logic                 hs_a, hs_b;
  logic [DW-1:0]        out_q [NUM_PORTS];
  logic [DW-1:0]        dir_q [NUM_PORTS];
  logic [DW-1:0]        view  [NUM_PORTS];

  gpio_decode #(.AW(AW)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bus_wr),
    .addr   (bus_addr),
    .wr_dat (wr_dat),
    .wr_dir (wr_dir),
    .hs_a   (hs_a),
    .hs_b   (hs_b)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    gpio_port_reg #(.DW(DW)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_dat (wr_dat[p]),
      .wr_dir (wr_dir[p]),
      .wdata  (bus_wdata),
      .out_q  (out_q[p]),
      .dir_q  (dir_q[p]),
      .view   (view[p])
    );
  end

  gpio_flag_pulse u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_a    (hs_a),
    .clr_b    (hs_b),
    .flag_clr (flag_clr)
  );

  always_comb begin
    pa_out = out_q[PORT_A];
    pa_oe  = dir_q[PORT_A];
    pb_out = out_q[PORT_B];
    pb_oe  = dir_q[PORT_B];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(OFS_PB_DATA))
      bus_rdata = view[PORT_B];
    else if (bus_addr == AW'(OFS_PA_DATA) || bus_addr == AW'(OFS_PA_QUIET))
      bus_rdata = view[PORT_A];
    else if (bus_addr == AW'(OFS_PB_DIR))
      bus_rdata = dir_q[PORT_B];
    else if (bus_addr == AW'(OFS_PA_DIR))
      bus_rdata = dir_q[PORT_A];
  end

  // R3
  input_reads_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(OFS_PA_DATA)) |-> ((bus_rdata | pa_oe) == '1))
    else $error("input pin of port A did not read as 1");

  // R4
  pin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pa_out) && $stable(pb_out) && $stable(pa_oe) && $stable(pb_oe))
    else $error("pins moved without a bus write");

endmodule

// File: tb/gpio_dual_port_tb.sv
module gpio_dual_port_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata, pa_out, pa_oe, pb_out, pb_oe;
  logic [3:0] flag_clr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_dual_port u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pa_out    (pa_out),
    .pa_oe     (pa_oe),
    .pb_out    (pb_out),
    .pb_oe     (pb_oe),
    .flag_clr  (flag_clr)
  );

  // {write offset, write data, read offset, expected read, expected flag_clr}
  localparam int NV = 13;
  localparam logic [27:0] VEC [NV] = '{
    {4'h3, 8'hF0, 4'h3, 8'hF0, 4'h0},  // R1 dir A
    {4'h1, 8'hAB, 4'h1, 8'hAF, 4'hC},  // R2 R3 R5
    {4'hF, 8'h5C, 4'hF, 8'h5F, 4'h0},  // R2 R7 quiet
    {4'h2, 8'h0F, 4'h2, 8'h0F, 4'h0},  // R1 dir B
    {4'h0, 8'h36, 4'h0, 8'hF6, 4'h3},  // R2 R3 R6
    {4'h3, 8'h00, 4'h1, 8'hFF, 4'h0},  // R3 all inputs
    {4'h1, 8'hFF, 4'h1, 8'hFF, 4'hC},  // R2 masked to 0
    {4'h3, 8'hFF, 4'h1, 8'h00, 4'h0},  // R2 R3 stored zero shows
    {4'hF, 8'h3C, 4'h1, 8'h3C, 4'h0},  // R2 R7
    {4'h0, 8'hFF, 4'h0, 8'hFF, 4'h3},  // R6
    {4'h2, 8'hFF, 4'h0, 8'h0F, 4'h0},  // R3 R7
    {4'h5, 8'h77, 4'h0, 8'h0F, 4'h0},  // R8 write ignored
    {4'h4, 8'h11, 4'h4, 8'h00, 4'h0}   // R8 read zero
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1;
    bus_addr = a;
    bus_wdata = d;
  endtask

  task automatic idle_at(input logic [3:0] a);
    @(negedge clk);
    bus_wr = 1'b0;
    bus_addr = a;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R9 state during reset
    repeat (3) @(negedge clk);
    bus_addr = 4'h1;
    #1;
    check("R9", "rdata A in reset", bus_rdata, 8'hFF);
    check("R9", "pa_oe in reset", pa_oe, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    idle_at(4'h0);
    check("R9", "rdata B after reset", bus_rdata, 8'hFF);
    check("R9", "pb_oe after reset", pb_oe, 8'h00);
    check("R9", "flag_clr after reset", {4'h0, flag_clr}, 8'h00);
    idle_at(4'h3);
    check("R9", "dir A after reset", bus_rdata, 8'h00);

    // vector table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][27:24], VEC[i][23:16]);
      idle_at(VEC[i][15:12]);
      check("R1/R2/R3/R5/R6/R7/R8", $sformatf("vector %0d rdata", i),
            bus_rdata, VEC[i][11:4]);
      check("R5/R6/R7", $sformatf("vector %0d flag_clr", i),
            {4'h0, flag_clr}, {4'h0, VEC[i][3:0]});
    end

    // R4 pins follow registers
    check("R4", "pa_out", pa_out, 8'h3C);
    check("R4", "pa_oe", pa_oe, 8'hFF);
    check("R4", "pb_out", pb_out, 8'h0F);
    check("R4", "pb_oe", pb_oe, 8'hFF);

    // R5 pulse lasts one cycle: port A write then a quiet write
    wr(4'h1, 8'h81);
    wr(4'hF, 8'h42);
    #1;
    check("R5", "pulse cycle", {4'h0, flag_clr}, 8'h0C);
    idle_at(4'h1);
    check("R5", "cycle after pulse", {4'h0, flag_clr}, 8'h00);
    check("R2", "quiet write data", bus_rdata, 8'h42);

    // R8 unmapped write leaves pins untouched
    wr(4'h9, 8'h00);
    idle_at(4'h0);
    check("R8", "pb_out after unmapped write", pb_out, 8'h0F);
    check("R8", "pa_out after unmapped write", pa_out, 8'h42);

    // R9 reset from a loaded state
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9", "pa_out after reset", pa_out, 8'h00);
    check("R9", "pb_oe after reset", pb_oe, 8'h00);
    check("R9", "rdata B after reset", bus_rdata, 8'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    idle_at(4'h2);
    check("R9", "dir B after reset", bus_rdata, 8'h00);

    finish_run();
  end

endmodule